// File: doc/BRIEF.md
# Framed sample serializer

This block takes complex baseband samples, 12-bit I and 12-bit Q for each of two channels, and sends them onto a 6-bit word-serial bus. Alongside the words it drives a frame strobe that marks where each sample sits in the frame. Everything runs at word rate in a single clock domain. Each sample takes four words. A frame period is eight words.

There are two modes. In two-channel mode a period carries one channel-0 sample followed by one channel-1 sample. In single-channel mode a period carries two consecutive samples of one channel, so that channel goes out at twice the sample rate. A select input names the channel. The mode and the select take effect only at the start of a period.

The sample source works by request and response. The block raises a one-cycle request in the last word of every segment it consumes. A load strobe in that same cycle supplies the sample for the next segment. A load at any other time replaces the pending sample. If no load arrives, the pending sample is sent again.

Top module: `smp_word_tx`

## Requirements
- R1: While reset is asserted, and afterwards until the first load, tx_word is 0 and tx_frame and smp_req are 0. A load seen while idle starts a period: its first word appears in the next cycle.
- R2: A sample is sent as four words in this order: I[11:6], Q[11:6], I[5:0], Q[5:0].
- R3: With two_ch=1, an eight-word period carries the channel-0 sample in words 0-3 and the channel-1 sample in words 4-7. tx_frame over the period is 1,1,1,1,0,0,0,0.
- R4: With two_ch=0, tx_frame over each eight-word period is 1,1,0,0,1,1,0,0.
- R5: With two_ch=0, ch_pick=0 sends the channel-0 inputs and ch_pick=1 sends the channel-1 inputs.
- R6: With two_ch=0, words 0-3 carry the sample pending at the start of the period. Words 4-7 carry the sample pending at the end of word 3. With a source that answers every request, the sample counts in the two halves of a period differ by one, and the counts advance by two from one period to the next.
- R7: smp_req is high for exactly one cycle: word 7 of each period with two_ch=1, or words 3 and 7 with two_ch=0. A load in a request cycle supplies the next segment. A load at any other time overwrites the pending sample, and the last load wins. With no load, the previous pending sample is sent again.
- R8: two_ch and ch_pick are sampled only at the edge that starts a period. A change during a period has no effect until the next period.
- R9: Once started, periods follow each other with no idle words between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_ld | input | 1 | Load strobe for the four sample inputs |
| two_ch | input | 1 | 1 = two-channel mode, 0 = single-channel double-rate mode |
| ch_pick | input | 1 | Channel sent in single-channel mode (0 or 1) |
| ch0_i | input | 12 | Channel 0 in-phase sample |
| ch0_q | input | 12 | Channel 0 quadrature sample |
| ch1_i | input | 12 | Channel 1 in-phase sample |
| ch1_q | input | 12 | Channel 1 quadrature sample |
| tx_word | output | 6 | Serial data word |
| tx_frame | output | 1 | Frame strobe |
| smp_req | output | 1 | One-cycle request for the next sample |

## Verification
The bench changes the mode and the channel select in the middle of a period. A design that sampled them early would send a period with a mixed frame shape or mixed channels. It runs single-channel mode with sequential counts. A design that loaded the second half at the wrong time would show equal counts or swapped halves. It stops answering requests and also loads outside request cycles. A design without the same-cycle bypass, or without a held pending sample, would then send stale or missing data. Finally, it resets in the middle of a run to confirm that the outputs fall silent and that the next period restarts cleanly at word 0.

// File: rtl/smp_tx_pkg.sv
package smp_tx_pkg;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CH_N   = 2;

  typedef enum logic [1:0] {
    PH_I_HI = 2'd0,
    PH_Q_HI = 2'd1,
    PH_I_LO = 2'd2,
    PH_Q_LO = 2'd3
  } phase_e;
endpackage

// File: rtl/smp_tx_stage.sv
module smp_tx_stage
  import smp_tx_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic [CH_N-1:0][SMP_W-1:0]  in_i,
  input  logic [CH_N-1:0][SMP_W-1:0]  in_q,
  output logic [CH_N-1:0][SMP_W-1:0]  src_i,
  output logic [CH_N-1:0][SMP_W-1:0]  src_q
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [SMP_W-1:0] pend_i, pend_q;
    logic [SMP_W-1:0] pend_i_n, pend_q_n;

    always_comb begin
      pend_i_n = pend_i;
      pend_q_n = pend_q;
      if (ld) begin
        pend_i_n = in_i[c];
        pend_q_n = in_q[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_i <= '0;
        pend_q <= '0;
      end else begin
        pend_i <= pend_i_n;
        pend_q <= pend_q_n;
      end
    end

    // a load in the same cycle bypasses the pending register
    assign src_i[c] = ld ? in_i[c] : pend_i;
    assign src_q[c] = ld ? in_q[c] : pend_q;
  end
endmodule

// File: rtl/smp_tx_seq.sv
module smp_tx_seq
  import smp_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              two_ch,
  input  logic              ch_pick,
  output logic              running,
  output logic [SLOT_W-1:0] slot,
  output logic              dual_q,
  output logic              sel_q,
  output logic              cap_period,
  output logic              cap_half,
  output logic              req
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] MID  = SLOT_W'(SLOTS / 2 - 1);

  logic              running_n;
  logic [SLOT_W-1:0] slot_n;
  logic              dual_n, sel_n;
  logic              wrap, start;

  always_comb begin
    start      = !running && ld;
    wrap       = running && (slot == LAST);
    cap_period = start || wrap;
    cap_half   = running && !dual_q && (slot == MID);
    req        = wrap || cap_half;
    running_n  = running || ld;
    slot_n     = running ? slot + SLOT_W'(1) : '0;
    dual_n     = dual_q;
    sel_n      = sel_q;
    if (cap_period) begin
      dual_n = two_ch;
      sel_n  = ch_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot    <= '0;
      dual_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      running <= running_n;
      slot    <= slot_n;
      dual_q  <= dual_n;
      sel_q   <= sel_n;
    end
  end
endmodule

// File: rtl/smp_tx_hold.sv
module smp_tx_hold
  import smp_tx_pkg::*;
#(
  parameter int SMP_W  = 12,
  localparam int WORD_W = SMP_W / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_period,
  input  logic                        cap_half,
  input  logic                        two_ch,
  input  logic                        ch_pick,
  input  logic                        sel_q,
  input  logic                        running,
  input  logic                        dual_q,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [CH_N-1:0][SMP_W-1:0]  src_i,
  input  logic [CH_N-1:0][SMP_W-1:0]  src_q,
  output logic [WORD_W-1:0]           tx_word,
  output logic                        tx_frame
);
  // h*[0] feeds words 0-3, h*[1] feeds words 4-7
  logic [1:0][SMP_W-1:0] hi_q, hq_q, hi_n, hq_n;
  logic [SMP_W-1:0]      cur_i, cur_q;
  logic                  upper;

  always_comb begin
    hi_n = hi_q;
    hq_n = hq_q;
    if (cap_period) begin
      hi_n[0] = two_ch ? src_i[0] : src_i[ch_pick];
      hq_n[0] = two_ch ? src_q[0] : src_q[ch_pick];
      if (two_ch) begin
        hi_n[1] = src_i[1];
        hq_n[1] = src_q[1];
      end
    end else if (cap_half) begin
      hi_n[1] = src_i[sel_q];
      hq_n[1] = src_q[sel_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      hq_q <= '0;
    end else begin
      hi_q <= hi_n;
      hq_q <= hq_n;
    end
  end

  always_comb begin
    upper = slot[SLOT_W-1];
    cur_i = hi_q[upper];
    cur_q = hq_q[upper];
    unique case (phase_e'(slot[1:0]))
      PH_I_HI: tx_word = cur_i[SMP_W-1:WORD_W];
      PH_Q_HI: tx_word = cur_q[SMP_W-1:WORD_W];
      PH_I_LO: tx_word = cur_i[WORD_W-1:0];
      default: tx_word = cur_q[WORD_W-1:0];
    endcase
    if (!running) tx_word = '0;
    tx_frame = running && (dual_q ? !slot[SLOT_W-1] : !slot[1]);
  end
endmodule

// File: rtl/smp_word_tx.sv
module smp_word_tx
  import smp_tx_pkg::*;
#(
  parameter int SMP_W  = 12,
  localparam int WORD_W = SMP_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_ld,
  input  logic              two_ch,
  input  logic              ch_pick,
  input  logic [SMP_W-1:0]  ch0_i,
  input  logic [SMP_W-1:0]  ch0_q,
  input  logic [SMP_W-1:0]  ch1_i,
  input  logic [SMP_W-1:0]  ch1_q,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_frame,
  output logic              smp_req
);
  logic [CH_N-1:0][SMP_W-1:0] in_i, in_q, src_i, src_q;
  logic                       running, dual_q, sel_q, cap_period, cap_half;
  logic [SLOT_W-1:0]          slot;

  assign in_i = {ch1_i, ch0_i};
  assign in_q = {ch1_q, ch0_q};

  smp_tx_stage #(.SMP_W(SMP_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (smp_ld),
    .in_i  (in_i),
    .in_q  (in_q),
    .src_i (src_i),
    .src_q (src_q)
  );

  smp_tx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (smp_ld),
    .two_ch     (two_ch),
    .ch_pick    (ch_pick),
    .running    (running),
    .slot       (slot),
    .dual_q     (dual_q),
    .sel_q      (sel_q),
    .cap_period (cap_period),
    .cap_half   (cap_half),
    .req        (smp_req)
  );

  smp_tx_hold #(.SMP_W(SMP_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_period (cap_period),
    .cap_half   (cap_half),
    .two_ch     (two_ch),
    .ch_pick    (ch_pick),
    .sel_q      (sel_q),
    .running    (running),
    .dual_q     (dual_q),
    .slot       (slot),
    .src_i      (src_i),
    .src_q      (src_q),
    .tx_word    (tx_word),
    .tx_frame   (tx_frame)
  );
endmodule

// File: rtl/smp_word_tx_chk.sv
module smp_word_tx_chk
  import smp_tx_pkg::*;
#(
  parameter int WORD_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_ld,
  input logic              running,
  input logic [SLOT_W-1:0] slot,
  input logic              dual_q,
  input logic              smp_req,
  input logic [WORD_W-1:0] tx_word,
  input logic              tx_frame
);
  // R1: quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (tx_word == '0) && !tx_frame && !smp_req);

  // R1: a period only starts after a load
  a_r1_start_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(smp_ld));

  // R9: the last word is followed directly by word 0
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    running && (slot == SLOT_W'(SLOTS - 1)) |=> running && (slot == '0));

  // R8: the mode does not change inside a period
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    running && (slot != '0) |-> $stable(dual_q));

  // R7: the request is a single-cycle pulse
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |=> !smp_req);

  // R4: the frame strobe is high for at least two words
  a_r4_frame_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_frame) |=> tx_frame);
endmodule

bind smp_word_tx smp_word_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_ld   (smp_ld),
  .running  (running),
  .slot     (slot),
  .dual_q   (dual_q),
  .smp_req  (smp_req),
  .tx_word  (tx_word),
  .tx_frame (tx_frame)
);

// File: tb/smp_word_tx_tb_top.sv
`timescale 1ns/1ps
module smp_word_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_ld = 1'b0;
  logic        two_ch = 1'b1;
  logic        ch_pick = 1'b0;
  logic [11:0] ci0 = '0, cq0 = '0, ci1 = '0, cq1 = '0;
  logic [5:0]  tx_word;
  logic        tx_frame, smp_req;

  int    checks = 0;
  int    errors = 0;
  int    cnt = 0;
  bit    feed = 1'b0;
  string ph = "R1";

  always #5 clk = ~clk;

  smp_word_tx dut_i (
    .clk(clk), .rst_n(rst_n), .smp_ld(smp_ld), .two_ch(two_ch), .ch_pick(ch_pick),
    .ch0_i(ci0), .ch0_q(cq0), .ch1_i(ci1), .ch1_q(cq1),
    .tx_word(tx_word), .tx_frame(tx_frame), .smp_req(smp_req)
  );

  // ---------------- behavioural reference model ----------------
  int          exp_q[$];
  bit          m_run = 1'b0, m_dual = 1'b0, m_sel = 1'b0, m_half = 1'b0;
  logic [11:0] pend[4] = '{default: '0};
  logic [11:0] s[4];

  function automatic void push4(logic [11:0] i, logic [11:0] q, bit fa, bit fb);
    exp_q.push_back({fa, i[11:6]});
    exp_q.push_back({fa, q[11:6]});
    exp_q.push_back({fb, i[5:0]});
    exp_q.push_back({fb, q[5:0]});
  endfunction

  function automatic void new_period();
    m_dual = two_ch;
    m_sel  = ch_pick;
    m_half = 1'b0;
    if (m_dual) begin
      push4(s[0], s[1], 1'b1, 1'b1);
      push4(s[2], s[3], 1'b0, 1'b0);
    end else if (m_sel) push4(s[2], s[3], 1'b1, 1'b0);
    else                push4(s[0], s[1], 1'b1, 1'b0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 1'b0; m_half = 1'b0; exp_q.delete();
      pend = '{default: '0};
    end else begin
      if (smp_ld) begin
        s = '{ci0, cq0, ci1, cq1};
        pend = s;
      end else s = pend;
      if (!m_run) begin
        if (smp_ld) begin m_run = 1'b1; new_period(); end
      end else begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin
          if (!m_dual && !m_half) begin
            m_half = 1'b1;
            if (m_sel) push4(s[2], s[3], 1'b1, 1'b0);
            else       push4(s[0], s[1], 1'b1, 1'b0);
          end else new_period();
        end
      end
    end
  end

  // ---------------- checking and driving ----------------
  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic set_inputs(int c);
    ci0 = {4'hA, c[7:0]}; cq0 = {4'hB, c[7:0]};
    ci1 = {4'hC, c[7:0]}; cq1 = {4'hD, c[7:0]};
  endtask

  task automatic step();
    int e;
    @(negedge clk);
    e = (m_run && exp_q.size() > 0) ? exp_q[0] : 0;
    chk(ph, "word",  int'(tx_word),  e & 63);
    chk(ph, "frame", int'(tx_frame), (e >> 6) & 1);
    chk(ph, "req",   int'(smp_req),  (m_run && exp_q.size() == 1) ? 1 : 0);
    if (feed && smp_req) begin
      set_inputs(cnt); cnt++; smp_ld = 1'b1;
    end else smp_ld = 1'b0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset and idle, inputs busy but no load
    set_inputs(99);
    run(4);
    @(negedge clk); rst_n = 1'b1;
    two_ch = 1'b0;
    run(3);
    two_ch = 1'b1;
    run(3);

    // R3 R2 R9: two-channel periods, source answers each request
    ph = "R3 R2 R9";
    @(negedge clk); set_inputs(cnt); cnt++; smp_ld = 1'b1; feed = 1'b1;
    run(48);

    // R8 R4 R6: switch to single-channel in the middle of a period
    ph = "R8 R4 R6";
    run(3);
    two_ch = 1'b0;
    run(40);

    // R5: select channel 1 mid-period, later back to 0
    ph = "R5 R8";
    run(2);
    ch_pick = 1'b1;
    run(34);
    ch_pick = 1'b0;
    run(17);

    // R7: stop answering (repeat), then load outside a request cycle
    ph = "R7";
    feed = 1'b0;
    run(20);
    @(negedge clk); set_inputs(200); smp_ld = 1'b1;
    @(negedge clk); set_inputs(201); smp_ld = 1'b1;
    @(negedge clk); smp_ld = 1'b0; set_inputs(7);
    run(20);
    feed = 1'b1;
    two_ch = 1'b1;
    run(30);

    // R1: reset in the middle of a run, then restart at word 0
    ph = "R1";
    @(negedge clk); rst_n = 1'b0; smp_ld = 1'b0; feed = 1'b0;
    run(3);
    @(negedge clk); rst_n = 1'b1;
    run(4);
    two_ch = 1'b0; ch_pick = 1'b1;
    @(negedge clk); set_inputs(cnt); cnt++; smp_ld = 1'b1; feed = 1'b1;
    run(24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule